// File: doc/BRIEF.md
# Doorbell Interrupt Unit

The block raises software interrupts between processors and turns inbound message writes into per-processor interrupts. A single trigger word names one of 32 doorbells and a bitmap of target processors. Each targeted processor latches that doorbell in its own 32-bit pending register. Every processor also has a 32-bit enable register. Two summary lines per processor are derived from these registers: one covers the inter-processor group (doorbells 0 to 7), and one covers the message group (doorbells 16 to 31). Doorbells 8 to 15 latch like any other doorbell but feed neither summary.

The trigger word can arrive on two paths. The first is the register bus, through the shared window. The second is a dedicated inbound write port, which carries message writes that come from the I/O side. Software services a doorbell by writing its processor's pending register. Every bit written as 0 is cleared, and every bit written as 1 is left as it was. Reads are registered and return data one cycle after the read strobe.

Top module: `dbl_unit`

## Requirements
- R1: After reset every pending and enable register reads 0, and all summary outputs are low.
- R2: A bus write to shared offset 0x04 (`bus_shared`=1) sets doorbell `wdata[4:0]` in the pending register of each processor c whose bit `wdata[8+c]` is 1. The pending registers of the other processors are unchanged.
- R3: Trigger word bits [7:5] and [31:12] have no effect on any pending register.
- R4: An inbound message write of 0xF00 | (n+16) on `msg_data` sets bit 16+n in the pending register of all four processors, for n = 0..15.
- R5: A write to a processor's pending register (per-processor offset 0x08, `bus_shared`=0, `bus_cpu` selects the processor) clears each bit written as 0 and keeps each bit written as 1. Writing 0 clears the whole register.
- R6: The enable register at per-processor offset 0x0C is written and read back as a full 32-bit value.
- R7: `ipi_irq[c]` is high exactly when some bit in 0..7 is set in both the pending and the enable register of processor c.
- R8: `msi_irq[c]` is high exactly when some bit in 16..31 is set in both the pending and the enable register of processor c.
- R9: Doorbells 8..15 are latched in the pending register but never raise either summary.
- R10: When a trigger sets a bit in the same cycle that a pending-register write clears it, the bit ends up set.
- R11: A read returns data in the cycle after `bus_rd`. A shared-window read (including offset 0x04) returns 0. Per-processor reads at 0x08 and 0x0C return the pending and enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_shared | input | 1 | 1 selects the shared window, 0 the per-processor window |
| bus_cpu | input | 2 | Processor selected in the per-processor window |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msg_wr | input | 1 | Inbound trigger write strobe |
| msg_data | input | 32 | Inbound trigger word |
| ipi_irq | output | 4 | Inter-processor group summary, one bit per processor |
| msi_irq | output | 4 | Message group summary, one bit per processor |

## Verification
The assertions assume that the strobes are clean 0/1 levels. They also assume that a bus read and a bus write never target the same register in one cycle, so a read always sees the value held before the cycle. The stimulus drives every input on the falling edge and issues reads only on idle cycles. The one deliberate collision, a message trigger overlapping a pending-register clear, is aimed at the bit under test, so the set-priority check sees a defined outcome.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  localparam int DB_W = 32;
  typedef logic [DB_W-1:0] db_vec_t;

  localparam int OFS_TRIG  = 'h04;
  localparam int OFS_CAUSE = 'h08;
  localparam int OFS_MASK  = 'h0C;

  // Contiguous bit span [lo..hi] inside a doorbell vector.
  function automatic db_vec_t span_mask(input int lo, input int hi);
    db_vec_t m;
    for (int i = 0; i < DB_W; i++) begin
      m[i] = (i >= lo) && (i <= hi);
    end
    return m;
  endfunction

endpackage

// File: rtl/dbl_trig_decode.sv
module dbl_trig_decode
  import dbl_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int ADDR_W  = 8,
  parameter int TGT_LSB = 8
) (
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DB_W-1:0]            word_i,
  output logic [NCPU-1:0][DB_W-1:0]  set_o
);

  localparam int NUM_W = $clog2(DB_W);
  localparam db_vec_t USED_M = span_mask(0, NUM_W-1) | span_mask(TGT_LSB, TGT_LSB+NCPU-1);

  logic    hit;
  db_vec_t onehot;
  logic    unused_word;

  assign unused_word = ^(word_i & ~USED_M);

  always_comb begin
    hit    = wr_i && (addr_i == ADDR_W'(OFS_TRIG));
    onehot = db_vec_t'(1) << word_i[NUM_W-1:0];
    for (int c = 0; c < NCPU; c++) begin
      set_o[c] = (hit && word_i[TGT_LSB+c]) ? onehot : '0;
    end
  end

endmodule

// File: rtl/dbl_cpu_bank.sv
module dbl_cpu_bank
  import dbl_pkg::*;
#(
  parameter int IPI_LO = 0,
  parameter int IPI_HI = 7,
  parameter int MSI_LO = 16,
  parameter int MSI_HI = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] set_i,
  input  logic            clr_we_i,
  input  logic            mask_we_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [DB_W-1:0] cause_o,
  output logic [DB_W-1:0] mask_o,
  output logic            ipi_o,
  output logic            msi_o
);

  localparam db_vec_t IPI_M = span_mask(IPI_LO, IPI_HI);
  localparam db_vec_t MSI_M = span_mask(MSI_LO, MSI_HI);

  db_vec_t cause_q, cause_d, mask_q, mask_d, live;
  logic    cause_en, mask_en;

  // next state: write-zero-to-clear, then set takes priority
  always_comb begin
    cause_en = clr_we_i | (|set_i);
    cause_d  = (clr_we_i ? (cause_q & wdata_i) : cause_q) | set_i;
    mask_en  = mask_we_i;
    mask_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    live  = cause_q & mask_q;
    ipi_o = |(live & IPI_M);
    msi_o = |(live & MSI_M);
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !(|set_i)) |=> (cause_q == ($past(cause_q) & $past(wdata_i))));

  a_r2_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i && !(|set_i)) |=> $stable(cause_q));

  a_r6_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_q));

endmodule

// File: rtl/dbl_rd_mux.sv
module dbl_rd_mux
  import dbl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int CPU_W  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_i,
  input  logic                       shared_i,
  input  logic [CPU_W-1:0]           cpu_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NCPU-1:0][DB_W-1:0]  cause_i,
  input  logic [NCPU-1:0][DB_W-1:0]  mask_i,
  output logic [DB_W-1:0]            rdata_o
);

  db_vec_t rdata_q, rdata_d, cause_sel, mask_sel;
  logic    cpu_ok;

  generate
    if (NCPU == (1 << CPU_W)) begin : g_full
      assign cpu_ok = 1'b1;
    end else begin : g_part
      assign cpu_ok = (int'(cpu_i) < NCPU);
    end
  endgenerate

  always_comb begin
    cause_sel = '0;
    mask_sel  = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (cpu_i == CPU_W'(c)) begin
        cause_sel = cause_i[c];
        mask_sel  = mask_i[c];
      end
    end
    rdata_d = '0;
    if (!shared_i && cpu_ok) begin
      if (addr_i == ADDR_W'(OFS_CAUSE))     rdata_d = cause_sel;
      else if (addr_i == ADDR_W'(OFS_MASK)) rdata_d = mask_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r11_shared_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && shared_i) |=> (rdata_o == '0));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/dbl_unit.sv
module dbl_unit
  import dbl_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int ADDR_W  = 8,
  parameter int TGT_LSB = 8,
  parameter int IPI_LO  = 0,
  parameter int IPI_HI  = 7,
  parameter int MSI_LO  = 16,
  parameter int MSI_HI  = 31,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_shared,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DB_W-1:0]   bus_wdata,
  output logic [DB_W-1:0]   bus_rdata,
  input  logic              msg_wr,
  input  logic [DB_W-1:0]   msg_data,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   msi_irq
);

  logic [NCPU-1:0][DB_W-1:0] set_bus, set_msg, set_all;
  logic [NCPU-1:0][DB_W-1:0] cause_all, mask_all;

  dbl_trig_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W), .TGT_LSB(TGT_LSB)) u_dec_bus (
    .wr_i   (bus_wr && bus_shared),
    .addr_i (bus_addr),
    .word_i (bus_wdata),
    .set_o  (set_bus)
  );

  dbl_trig_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W), .TGT_LSB(TGT_LSB)) u_dec_msg (
    .wr_i   (msg_wr),
    .addr_i (ADDR_W'(OFS_TRIG)),
    .word_i (msg_data),
    .set_o  (set_msg)
  );

  assign set_all = set_bus | set_msg;

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic sel_c, clr_we, mask_we;
      assign sel_c   = bus_wr && !bus_shared && (bus_cpu == CPU_W'(c));
      assign clr_we  = sel_c && (bus_addr == ADDR_W'(OFS_CAUSE));
      assign mask_we = sel_c && (bus_addr == ADDR_W'(OFS_MASK));

      dbl_cpu_bank #(.IPI_LO(IPI_LO), .IPI_HI(IPI_HI), .MSI_LO(MSI_LO), .MSI_HI(MSI_HI)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_all[c]),
        .clr_we_i  (clr_we),
        .mask_we_i (mask_we),
        .wdata_i   (bus_wdata),
        .cause_o   (cause_all[c]),
        .mask_o    (mask_all[c]),
        .ipi_o     (ipi_irq[c]),
        .msi_o     (msi_irq[c])
      );
    end
  endgenerate

  dbl_rd_mux #(.NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (bus_rd),
    .shared_i (bus_shared),
    .cpu_i    (bus_cpu),
    .addr_i   (bus_addr),
    .cause_i  (cause_all),
    .mask_i   (mask_all),
    .rdata_o  (bus_rdata)
  );

  a_r7_ipi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '0) |-> (ipi_irq == '0) && (msi_irq == '0));

endmodule

// File: tb/sim_dbl_unit.sv
`timescale 1ns/1ps
module sim_dbl_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, bus_shared;
  logic [1:0]  bus_cpu;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        msg_wr;
  logic [31:0] msg_data;
  logic [3:0]  ipi_irq, msi_irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dbl_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_shared(bus_shared), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_wr(msg_wr),
    .msg_data(msg_data), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  // behavioural reference
  logic [31:0] mc [4];
  logic [31:0] mm [4];
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin mc[c] = 0; mm[c] = 0; end
      m_rd = 0;
    end else begin
      if (bus_rd) begin
        if (bus_shared)           m_rd = 0;
        else if (bus_addr == 8)   m_rd = mc[bus_cpu];
        else if (bus_addr == 12)  m_rd = mm[bus_cpu];
        else                      m_rd = 0;
      end
      for (int c = 0; c < 4; c++) begin
        logic [31:0] nc;
        nc = mc[c];
        if (bus_wr && !bus_shared && bus_cpu == c && bus_addr == 8) nc = nc & bus_wdata;
        if (bus_wr && !bus_shared && bus_cpu == c && bus_addr == 12) mm[c] = bus_wdata;
        if (bus_wr && bus_shared && bus_addr == 4 && bus_wdata[8+c]) nc = nc | (32'd1 << bus_wdata[4:0]);
        if (msg_wr && msg_data[8+c]) nc = nc | (32'd1 << msg_data[4:0]);
        mc[c] = nc;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 4; c++) begin
        check({31'd0, ipi_irq[c]}, {31'd0, |(mc[c] & mm[c] & 32'h0000_00FF)}, "R7 ipi summary");
        check({31'd0, msi_irq[c]}, {31'd0, |(mc[c] & mm[c] & 32'hFFFF_0000)}, "R8 msi summary");
      end
      check(bus_rdata, m_rd, "R11 read data");
    end
  end

  task automatic bus_write(input logic sh, input logic [1:0] cpu, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_shared = sh; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic msg_write(input logic [31:0] d);
    @(negedge clk);
    msg_wr = 1; msg_data = d;
    @(negedge clk);
    msg_wr = 0;
  endtask

  task automatic read_chk(input logic sh, input logic [1:0] cpu, input logic [7:0] a,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_shared = sh; bus_cpu = cpu; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_shared = 0; bus_cpu = 0;
    bus_addr = 0; bus_wdata = 0; msg_wr = 0; msg_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check({28'd0, ipi_irq}, 0, "R1 ipi after reset");
    check({28'd0, msi_irq}, 0, "R1 msi after reset");
    for (int c = 0; c < 4; c++) begin
      read_chk(0, c[1:0], 8'h08, 0, "R1 pending after reset");
      read_chk(0, c[1:0], 8'h0C, 0, "R1 enable after reset");
    end

    // R6 enable registers
    bus_write(0, 0, 8'h0C, 32'hFFFF_FFFF);
    bus_write(0, 1, 8'h0C, 32'h0000_00FF);
    bus_write(0, 2, 8'h0C, 32'hFFFF_0000);
    bus_write(0, 3, 8'h0C, 32'hFFFF_FFFF);
    read_chk(0, 1, 8'h0C, 32'h0000_00FF, "R6 enable cpu1");
    read_chk(0, 2, 8'h0C, 32'hFFFF_0000, "R6 enable cpu2");

    // R2 targeted trigger: doorbell 3 to cpus 0 and 2
    bus_write(1, 0, 8'h04, 32'h0000_0503);
    read_chk(0, 0, 8'h08, 32'h0000_0008, "R2 cpu0 set");
    read_chk(0, 1, 8'h08, 32'h0000_0000, "R2 cpu1 untouched");
    read_chk(0, 2, 8'h08, 32'h0000_0008, "R2 cpu2 set");
    check({31'd0, ipi_irq[0]}, 1, "R7 cpu0 ipi raised");
    check({31'd0, ipi_irq[2]}, 0, "R7 cpu2 ipi disabled");

    // R3 junk bits ignored: doorbell 5 to cpu1 only
    bus_write(1, 0, 8'h04, 32'hFFFF_F2E5);
    read_chk(0, 1, 8'h08, 32'h0000_0020, "R3 cpu1 only bit5");
    read_chk(0, 0, 8'h08, 32'h0000_0008, "R3 cpu0 untouched");
    read_chk(0, 3, 8'h08, 32'h0000_0000, "R3 cpu3 untouched");

    // R9 gap doorbell 10 on cpu3 with everything enabled
    bus_write(1, 0, 8'h04, 32'h0000_080A);
    read_chk(0, 3, 8'h08, 32'h0000_0400, "R9 gap bit latched");
    check({30'd0, ipi_irq[3], msi_irq[3]}, 0, "R9 gap raises nothing");

    // R4 message writes n=0 and n=15
    msg_write(32'h0000_0F10);
    msg_write(32'h0000_0F1F);
    read_chk(0, 3, 8'h08, 32'h8001_0400, "R4 cpu3 msi bits");
    read_chk(0, 1, 8'h08, 32'h8001_0020, "R4 cpu1 msi bits");
    check({31'd0, msi_irq[2]}, 1, "R8 cpu2 msi raised");
    check({31'd0, msi_irq[1]}, 0, "R8 cpu1 msi disabled");

    // R5 write-zero-to-clear
    bus_write(0, 0, 8'h08, ~32'h0000_0008);
    read_chk(0, 0, 8'h08, 32'h8001_0000, "R5 selective clear");
    check({31'd0, ipi_irq[0]}, 0, "R5 ipi dropped");
    bus_write(0, 0, 8'h08, 32'h0);
    read_chk(0, 0, 8'h08, 32'h0, "R5 clear all");
    read_chk(0, 1, 8'h08, 32'h8001_0020, "R5 other cpu kept");

    // R10 set wins over same-cycle clear on cpu1 doorbell 2
    @(negedge clk);
    bus_wr = 1; bus_shared = 0; bus_cpu = 1; bus_addr = 8'h08; bus_wdata = 32'h0;
    msg_wr = 1; msg_data = 32'h0000_0202;
    @(negedge clk);
    bus_wr = 0; msg_wr = 0;
    read_chk(0, 1, 8'h08, 32'h0000_0004, "R10 set wins");

    // R11 shared read of trigger returns zero
    read_chk(1, 0, 8'h04, 32'h0, "R11 trigger reads zero");

    // R8 disabling removes msi on cpu2 while pending stays
    bus_write(0, 2, 8'h0C, 32'h0);
    check({31'd0, msi_irq[2]}, 0, "R8 msi masked off");
    read_chk(0, 2, 8'h08, 32'h8001_0008, "R8 pending retained");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule